// File: doc/BRIEF.md
# Interrupt status and mask unit

This block gathers per-channel line status (loop closure, constant-current feeding, level-meter ready, tone detected, caller-ID request) into status registers the host can read, and folds every pending event from all channels into one shared active-low interrupt line. Each change of a status value leaves a pending event behind. That event holds the interrupt line low until the host reads the register that holds the bit. Per-bit mask inputs keep an event off the line, but they never stop the status value from following its source.

The loop-closure and constant-current inputs pass through programmable debounce counters before they reach the status registers. A reset-status flag comes up set after reset and asserts the interrupt until software reads it away. A channel-indication bit shows which channel raised the latest unmasked event.

The host reads the block through a simple strobe: a channel number, a register select and an enable. The addressed register value appears on the read-data port one cycle later.

Top module: `intstat_top`

## Requirements
- R1: A change in either direction of the hook (register A bit 0), constant-current (A bit 1), level-meter-ready (A bit 2) or tone-detect (A bit 3) status sets a pending event. For the level-meter and tone inputs, irqN goes low in the cycle after the input changes, and the new value is shown in register A.
- R2: The caller-ID request status (register B bit 0) raises an event only on a 0-to-1 change. A 1-to-0 change updates the bit and leaves irqN high.
- R3: Mask bits of channel c sit at evMask[6c+k]: k=0 hook, 1 constant current, 2 level meter, 3 tone, 4 caller-ID, 5 reset flag. A set mask bit keeps that event off irqN, but the status bit still updates.
- R4: irqN is low while any unmasked event is pending. Reading register A clears the pending events of bits 0 to 3 of that channel. Reading register B clears the caller-ID event and the reset flag. Neither read changes the other status values.
- R5: Register A bit 7 (channel indication) is set by an unmasked event of that channel. Reading register A alone leaves it set. It clears once both registers of the channel have been read after the event.
- R6: After reset, register B of every channel reads 0x20 (bit 5 is the reset flag) and irqN is low unless mask bit 5 is set. A read of register B clears the flag.
- R7: Hook and constant-current inputs reach the status only after holding a new value for HOOK_CYC or CC_CYC consecutive cycles. The status then shows the value one cycle later. Any return to the old value restarts the count.
- R8: rdData is 0 after reset and takes the addressed register value (rdSel 0 = A, 1 = B) on the clock edge where rdEn is high. It holds its value in every other cycle.
- R9: An event that occurs on the same edge as a read of its register stays pending. The read returns the value from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hookRaw | input | NCH | Undebounced loop-closure input per channel |
| ccRaw | input | NCH | Undebounced constant-current input per channel |
| lmReady | input | NCH | Level-meter result ready per channel |
| toneDet | input | NCH | Tone detected per channel |
| cidReq | input | NCH | Caller-ID data request per channel |
| evMask | input | 6*NCH | Event mask bits, 6 per channel |
| rdEn | input | 1 | Read strobe |
| rdChan | input | CW | Channel to read |
| rdSel | input | 1 | Register select: 0 = A, 1 = B |
| rdData | output | 8 | Registered read data |
| irqN | output | 1 | Shared interrupt, active low |

## Verification
A change on a level-meter, tone or caller-ID input reaches irqN after one clock edge. A debounced input needs its full count plus one edge before irqN falls, so the bench checks it high one cycle early and low at the due cycle. Read data is registered, and pending events clear on the edge that carries rdEn, so the read value and the released irqN are both taken at the falling edge after that read edge. Every sample falls halfway between rising edges, and each wait is counted in whole cycles from the falling edge where the stimulus was driven.

// File: rtl/intstat_pkg.sv
package intstat_pkg;
  localparam int REG_W   = 8;
  localparam int EV_W    = 6;
  localparam int IND_BIT = 7;
  localparam int RST_BIT = 5;
  localparam int M_CID   = 4;
  localparam int M_RST   = 5;

  typedef struct packed {
    logic clrA;
    logic clrB;
  } clrStrb_t;
endpackage

// File: rtl/intstat_debounce.sv
module intstat_debounce #(
  parameter int LEN = 16,
  localparam int CNT_W = (LEN > 2) ? $clog2(LEN) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic raw,
  output logic filt
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt  <= '0;
      filt <= 1'b0;
    end else if (raw == filt) begin
      cnt <= '0;
    end else if (cnt == CNT_W'(LEN - 1)) begin
      filt <= raw;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/intstat_ctrl.sv
module intstat_ctrl
  import intstat_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                    rdEn,
  input  logic [CW-1:0]           rdChan,
  input  logic                    rdSel,
  output clrStrb_t [NCH-1:0]      strbs
);
  for (genvar c = 0; c < NCH; c++) begin : g_dec
    logic hit;
    assign hit         = rdEn && (rdChan == CW'(c));
    assign strbs[c].clrA = hit && !rdSel;
    assign strbs[c].clrB = hit && rdSel;
  end
endmodule

// File: rtl/intstat_dpath.sv
module intstat_dpath
  import intstat_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCH-1:0]        hookF,
  input  logic [NCH-1:0]        ccF,
  input  logic [NCH-1:0]        lmIn,
  input  logic [NCH-1:0]        toneIn,
  input  logic [NCH-1:0]        cidIn,
  input  logic [NCH*EV_W-1:0]   evMask,
  input  clrStrb_t [NCH-1:0]    strbs,
  input  logic                  rdEn,
  input  logic [CW-1:0]         rdChan,
  input  logic                  rdSel,
  output logic [REG_W-1:0]      rdData,
  output logic                  irqN
);
  logic [NCH-1:0][REG_W-1:0] regA;
  logic [NCH-1:0][REG_W-1:0] regB;
  logic [NCH-1:0]            chActive;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [3:0]      cur, statQ, pendAQ, chg;
    logic            cidQ, pendCidQ, rstQ, chanQ, seenAQ, seenBQ;
    logic            cidRise, anyEv, nextA, nextB;
    logic [EV_W-1:0] msk;

    assign msk     = evMask[c*EV_W +: EV_W];
    assign cur     = {toneIn[c], lmIn[c], ccF[c], hookF[c]};
    assign chg     = cur ^ statQ;
    assign cidRise = cidIn[c] & ~cidQ;
    assign anyEv   = (|(chg & ~msk[3:0])) | (cidRise & ~msk[M_CID]);
    assign nextA   = seenAQ | strbs[c].clrA;
    assign nextB   = seenBQ | strbs[c].clrB;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        statQ    <= '0;
        pendAQ   <= '0;
        cidQ     <= 1'b0;
        pendCidQ <= 1'b0;
        rstQ     <= 1'b1;
        chanQ    <= 1'b0;
        seenAQ   <= 1'b0;
        seenBQ   <= 1'b0;
      end else begin
        statQ    <= cur;
        cidQ     <= cidIn[c];
        pendAQ   <= (strbs[c].clrA ? 4'b0 : pendAQ) | chg;
        pendCidQ <= (strbs[c].clrB ? 1'b0 : pendCidQ) | cidRise;
        if (strbs[c].clrB) rstQ <= 1'b0;
        if (anyEv) begin
          chanQ  <= 1'b1;
          seenAQ <= 1'b0;
          seenBQ <= 1'b0;
        end else if (nextA && nextB) begin
          chanQ  <= 1'b0;
          seenAQ <= 1'b0;
          seenBQ <= 1'b0;
        end else begin
          seenAQ <= nextA;
          seenBQ <= nextB;
        end
      end
    end

    always_comb begin
      regA[c]          = '0;
      regA[c][3:0]     = statQ;
      regA[c][IND_BIT] = chanQ;
      regB[c]          = '0;
      regB[c][0]       = cidQ;
      regB[c][RST_BIT] = rstQ;
    end

    assign chActive[c] = (|(pendAQ & ~msk[3:0])) | (pendCidQ & ~msk[M_CID])
                       | (rstQ & ~msk[M_RST]);
  end

  assign irqN = ~(|chActive);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn && (32'(rdChan) < NCH)) begin
      rdData <= rdSel ? regB[rdChan] : regA[rdChan];
    end
  end
endmodule

// File: rtl/intstat_top.sv
module intstat_top
  import intstat_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int HOOK_CYC = 20000,
  parameter int CC_CYC   = 33000,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NCH-1:0]      hookRaw,
  input  logic [NCH-1:0]      ccRaw,
  input  logic [NCH-1:0]      lmReady,
  input  logic [NCH-1:0]      toneDet,
  input  logic [NCH-1:0]      cidReq,
  input  logic [NCH*6-1:0]    evMask,
  input  logic                rdEn,
  input  logic [CW-1:0]       rdChan,
  input  logic                rdSel,
  output logic [7:0]          rdData,
  output logic                irqN
);
  logic [NCH-1:0]       hookF, ccF;
  clrStrb_t [NCH-1:0]   strbs;

  for (genvar c = 0; c < NCH; c++) begin : g_deb
    intstat_debounce #(.LEN(HOOK_CYC)) hook_i (
      .clk(clk), .rstN(rstN), .raw(hookRaw[c]), .filt(hookF[c]));
    intstat_debounce #(.LEN(CC_CYC)) cc_i (
      .clk(clk), .rstN(rstN), .raw(ccRaw[c]), .filt(ccF[c]));
  end

  intstat_ctrl #(.NCH(NCH)) ctrl_i (
    .rdEn(rdEn), .rdChan(rdChan), .rdSel(rdSel), .strbs(strbs));

  intstat_dpath #(.NCH(NCH)) dpath_i (
    .clk(clk), .rstN(rstN), .hookF(hookF), .ccF(ccF), .lmIn(lmReady),
    .toneIn(toneDet), .cidIn(cidReq), .evMask(evMask), .strbs(strbs),
    .rdEn(rdEn), .rdChan(rdChan), .rdSel(rdSel), .rdData(rdData),
    .irqN(irqN));
endmodule

// File: rtl/intstat_chk.sv
module intstat_chk #(
  parameter int NCH = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqN,
  input logic             rdEn,
  input logic [7:0]       rdData,
  input logic [NCH*6-1:0] evMask
);
  logic firstCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) firstCyc <= 1'b1;
    else       firstCyc <= 1'b0;
  end

  // R3: with every event masked the line stays inactive
  p_irq_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (&evMask) |-> irqN);

  // R4: without a read and with masks unchanged an active line stays active
  p_irq_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!irqN && !rdEn) |=> (!irqN || !$stable(evMask)));

  // R8: read data only moves on a read strobe
  p_rd_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R6: the reset flag drives the line in the first cycle after reset
  p_rst_irq_r6: assert property (@(posedge clk) disable iff (!rstN)
    (firstCyc && !evMask[5]) |-> !irqN);
endmodule

bind intstat_top intstat_chk #(.NCH(NCH)) chk_i (
  .clk(clk), .rstN(rstN), .irqN(irqN), .rdEn(rdEn), .rdData(rdData),
  .evMask(evMask));

// File: tb/intstat_top_tb_top.sv
module intstat_top_tb_top;
  localparam int NCH  = 2;
  localparam int HLEN = 8;
  localparam int CLEN = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NCH-1:0] hookRaw = '0, ccRaw = '0, lmReady = '0, toneDet = '0, cidReq = '0;
  logic [NCH*6-1:0] evMask = '0;
  logic rdEn = 1'b0;
  logic [0:0] rdChan = '0;
  logic rdSel = 1'b0;
  logic [7:0] rdData;
  logic irqN;

  int nChk = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  intstat_top #(.NCH(NCH), .HOOK_CYC(HLEN), .CC_CYC(CLEN)) dut_i (
    .clk(clk), .rstN(rstN), .hookRaw(hookRaw), .ccRaw(ccRaw),
    .lmReady(lmReady), .toneDet(toneDet), .cidReq(cidReq), .evMask(evMask),
    .rdEn(rdEn), .rdChan(rdChan), .rdSel(rdSel), .rdData(rdData), .irqN(irqN));

  typedef struct packed {
    logic       ch;
    logic       lm;
    logic       tone;
    logic       cid;
    logic [5:0] mask;
    logic       expIrq;
    logic [7:0] expA;
    logic [7:0] expB;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b1, 1'b0, 1'b0, 6'h00, 1'b0, 8'h84, 8'h00},  // R1 rise
    '{1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 8'h80, 8'h00},  // R1 fall
    '{1'b1, 1'b0, 1'b1, 1'b0, 6'h00, 1'b0, 8'h88, 8'h00},  // R1 tone
    '{1'b1, 1'b0, 1'b1, 1'b1, 6'h00, 1'b0, 8'h88, 8'h01},  // R2 rise
    '{1'b1, 1'b0, 1'b1, 1'b0, 6'h00, 1'b1, 8'h08, 8'h00},  // R2 fall quiet
    '{1'b0, 1'b1, 1'b1, 1'b0, 6'h0C, 1'b1, 8'h0C, 8'h00},  // R3 masked
    '{1'b0, 1'b1, 1'b0, 1'b0, 6'h04, 1'b0, 8'h84, 8'h00},  // R3 partial
    '{1'b0, 1'b1, 1'b0, 1'b1, 6'h10, 1'b1, 8'h04, 8'h01},  // R3 cid masked
    '{1'b0, 1'b0, 1'b0, 1'b0, 6'h00, 1'b0, 8'h80, 8'h00}   // R1 clean up
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic rd(input int ch, input logic sel, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; rdChan = 1'(ch); rdSel = sel;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog act=running exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);
    // reset state
    chk("R6 irq after reset", 8'(irqN), 8'h00);
    chk("R8 rdData reset", rdData, 8'h00);
    rd(0, 1'b1, d); chk("R6 ch0 regB", d, 8'h20);
    chk("R6 irq while ch1 flag", 8'(irqN), 8'h00);
    rd(1, 1'b1, d); chk("R6 ch1 regB", d, 8'h20);
    chk("R6 irq released", 8'(irqN), 8'h01);
    rd(0, 1'b1, d); chk("R6 flag cleared", d, 8'h00);
    rd(0, 1'b0, d); chk("R4 ch0 regA idle", d, 8'h00);

    // vector table
    foreach (VECS[i]) begin
      @(negedge clk);
      lmReady[VECS[i].ch] = VECS[i].lm;
      toneDet[VECS[i].ch] = VECS[i].tone;
      cidReq[VECS[i].ch]  = VECS[i].cid;
      evMask = '0;
      evMask[VECS[i].ch*6 +: 6] = VECS[i].mask;
      @(negedge clk);
      chk($sformatf("R1/R2/R3 vec%0d irq", i), 8'(irqN), 8'(VECS[i].expIrq));
      rd(VECS[i].ch, 1'b0, d); chk($sformatf("R1/R5 vec%0d regA", i), d, VECS[i].expA);
      rd(VECS[i].ch, 1'b1, d); chk($sformatf("R2 vec%0d regB", i), d, VECS[i].expB);
      chk($sformatf("R4 vec%0d irq cleared", i), 8'(irqN), 8'h01);
    end
    evMask = '0;

    // R7 hook debounce on ch0
    @(negedge clk); hookRaw[0] = 1'b1;
    waitCyc(HLEN);
    chk("R7 hook before count", 8'(irqN), 8'h01);
    waitCyc(1);
    chk("R7 hook after count", 8'(irqN), 8'h00);
    rd(0, 1'b0, d); chk("R7 hook regA", d, 8'h81);
    rd(0, 1'b1, d); chk("R4 hook regB", d, 8'h00);

    // R7 glitch restarts the count
    @(negedge clk); hookRaw[0] = 1'b0;
    waitCyc(HLEN - 1);
    hookRaw[0] = 1'b1;
    waitCyc(1);
    hookRaw[0] = 1'b0;
    waitCyc(HLEN);
    chk("R7 glitch restart", 8'(irqN), 8'h01);
    waitCyc(1);
    chk("R7 after restart", 8'(irqN), 8'h00);
    rd(0, 1'b0, d); chk("R7 glitch regA", d, 8'h80);
    rd(0, 1'b1, d); chk("R4 glitch regB", d, 8'h00);

    // R7 constant-current debounce on ch1
    @(negedge clk); ccRaw[1] = 1'b1;
    waitCyc(CLEN);
    chk("R7 cc before count", 8'(irqN), 8'h01);
    waitCyc(1);
    chk("R7 cc after count", 8'(irqN), 8'h00);
    rd(1, 1'b0, d); chk("R7 cc regA", d, 8'h8A);
    rd(1, 1'b1, d); chk("R4 cc regB", d, 8'h00);

    // R5 channel indication needs both reads
    @(negedge clk); lmReady[1] = 1'b1;
    @(negedge clk);
    chk("R1 ch1 lm irq", 8'(irqN), 8'h00);
    rd(1, 1'b0, d); chk("R5 first regA", d, 8'h8E);
    rd(1, 1'b0, d); chk("R5 second regA", d, 8'h8E);
    chk("R4 irq after regA", 8'(irqN), 8'h01);
    rd(1, 1'b1, d); chk("R5 regB", d, 8'h00);
    rd(1, 1'b0, d); chk("R5 indication cleared", d, 8'h0E);

    // R9 change on the read edge stays pending
    @(negedge clk);
    toneDet[0] = 1'b1; rdEn = 1'b1; rdChan = 1'b0; rdSel = 1'b0;
    @(negedge clk);
    rdEn = 1'b0;
    chk("R9 read returns old value", rdData, 8'h00);
    chk("R9 event kept", 8'(irqN), 8'h00);
    rd(0, 1'b0, d); chk("R9 regA", d, 8'h88);
    rd(0, 1'b1, d); chk("R9 regB", d, 8'h00);
    chk("R9 irq cleared", 8'(irqN), 8'h01);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nChk, nFail);
    $finish;
  end
endmodule